// File: doc/BRIEF.md
# DRAM Training Pattern Engine

The engine holds a training pattern in a small on-chip buffer and replays it against DRAM without processor involvement. Software fills the buffer one 32-bit dword at a time through a pointer register and a data register. It then programs a line count and a DRAM target address and starts either a write pass, which streams the pattern out to memory, or a read pass. The read pass fetches the same lines back and checks each returned word against the buffer.

A read pass leaves a per-byte-lane failure map. One field covers the first 64-bit beat of each returned word and a second field covers the second beat. Inverting a field gives the lanes that passed. Each go bit is set by software and cleared by the engine when its pass completes, so software polls the control register for completion. The DRAM side is a plain request port. Each 128-bit word carries two 64-bit beats, writes are accepted every cycle, and read data returns later in request order with a valid strobe.

Top module: `train_pattern_engine`

## Requirements
- R1: Writing register 1 (buffer pointer) sets the dword index into the pattern buffer. Each write to register 2 (buffer data) stores the dword at that index and then advances the index by one, wrapping at LINES_MAX*16. Register 1 reads back the current index.
- R2: A write pass of L lines issues exactly 4*L memory writes, one per cycle, to consecutive word addresses starting at {high field, low field, 2'b00}. Word w carries buffer dwords 4w..4w+3, with dword 4w in bits 31:0. The low pointer is register 3 and the 2-bit high field is register 4.
- R3: Control register (register 0) bit 2 is the write go bit and bit 3 is the read go bit. The matching bit reads 1 from the cycle after a pass starts until the pass completes, and the engine then returns it to 0.
- R4: A pass starts only if all of these hold: the engine is idle, exactly one go bit is set in the written control value, and that value also sets the matching mode bit (bit 0 for write, bit 1 for read). Any other control write starts nothing, and no memory request follows it.
- R5: The line count is control bits 10:8. A go request with a count of 0, or a count above LINES_MAX, is refused.
- R6: Starting a pass resets the buffer pointer to 0, and the pass replays the pattern from dword 0 whatever the pointer held before.
- R7: A read pass of L lines issues 4*L read requests and compares the responses in order against buffer words 0..4*L-1. If every response matches, the status reads 0.
- R8: Status register 5, bit i of 7:0, is set when byte lane i of the low 64 bits of a response mismatches. Bit 8+i is set when lane i of the high 64 bits mismatches.
- R9: Status bits are sticky for the rest of a read pass and clear when the next read pass starts.
- R10: When the read go bit is first seen at 0, the status already includes the compare of the final response.
- R11: While a pass runs, writes to the buffer data, buffer pointer and control registers are ignored.
- R12: After reset, every register reads 0 and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Memory word address (byte address bits 39:4) |
| mem_wdata | output | 128 | Write data, two 64-bit beats |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 128 | Read response data |

## Verification
Two events can land in the same clock edge: the compare of the last response of a read pass, and the engine clearing the read go bit. The bench provokes this by corrupting only the final word of a four-line region. It then reads the status the first time the go bit reads 0 and expects the corrupted lane to be set. A second collision, between a register write and a running pass, is provoked by writing the buffer pointer, buffer data and control registers just after a pass starts. Afterwards the bench checks that the pointer, the control fields and the replayed pattern are unchanged.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int unsigned DWORD_W      = 32;
  localparam int unsigned LANES        = 8;
  localparam int unsigned BEAT_W       = 64;
  localparam int unsigned PORT_W       = 2 * BEAT_W;
  localparam int unsigned DW_PER_WORD  = PORT_W / DWORD_W;
  localparam int unsigned DW_PER_LINE  = 16;
  localparam int unsigned WORDS_PER_LN = DW_PER_LINE / DW_PER_WORD;
  localparam int unsigned LO_W         = 32;
  localparam int unsigned HI_W         = 2;
  localparam int unsigned BASE_W       = HI_W + LO_W;
  localparam int unsigned MEM_AW       = BASE_W + $clog2(WORDS_PER_LN);
  localparam int unsigned REG_AW       = 3;
  localparam int unsigned LEN_LSB      = 8;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL  = 3'd0,
    REG_BPTR  = 3'd1,
    REG_BDATA = 3'd2,
    REG_ALO   = 3'd3,
    REG_AHI   = 3'd4,
    REG_STAT  = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    PASS_IDLE = 2'd0,
    PASS_WR   = 2'd1,
    PASS_RD   = 2'd2
  } pass_e;
endpackage

// File: rtl/tpe_patbuf.sv
module tpe_patbuf
  import tpe_pkg::*;
#(
  parameter  int unsigned LINES_MAX = 4,
  localparam int unsigned DEPTH     = LINES_MAX * DW_PER_LINE,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned WIDX_W    = $clog2(LINES_MAX * WORDS_PER_LN)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DWORD_W-1:0] wr_data,
  input  logic [WIDX_W-1:0]  rd_word,
  output logic [PORT_W-1:0]  rd_data
);
  localparam int unsigned SUB_W = $clog2(DW_PER_WORD);

  logic [DWORD_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < DW_PER_WORD; g++) begin : g_slice
    assign rd_data[DWORD_W*g +: DWORD_W] = store_q[{rd_word, SUB_W'(g)}];
  end
endmodule

// File: rtl/tpe_seq.sv
module tpe_seq
  import tpe_pkg::*;
#(
  parameter  int unsigned LINES_MAX = 4,
  localparam int unsigned LEN_W     = $clog2(LINES_MAX + 1),
  localparam int unsigned CNT_W     = LEN_W + $clog2(WORDS_PER_LN),
  localparam int unsigned WIDX_W    = $clog2(LINES_MAX * WORDS_PER_LN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pass_e             start_kind,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [BASE_W-1:0] start_base,
  input  logic              rsp_valid,
  output pass_e             kind,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WIDX_W-1:0] issue_word,
  output logic [WIDX_W-1:0] rsp_word,
  output logic              rsp_take,
  output logic              done
);
  pass_e             kind_q, kind_d;
  logic [CNT_W-1:0]  issue_q, issue_d;
  logic [CNT_W-1:0]  rsp_q, rsp_d;
  logic [CNT_W-1:0]  total_q, total_d;
  logic [BASE_W-1:0] base_q, base_d;

  assign kind       = kind_q;
  assign mem_req    = (kind_q != PASS_IDLE) && (issue_q != total_q);
  assign mem_we     = mem_req && (kind_q == PASS_WR);
  assign mem_addr   = {base_q, {($clog2(WORDS_PER_LN)){1'b0}}} + MEM_AW'(issue_q);
  assign issue_word = issue_q[WIDX_W-1:0];
  assign rsp_word   = rsp_q[WIDX_W-1:0];
  assign rsp_take   = (kind_q == PASS_RD) && rsp_valid;
  assign done       = (mem_we && (issue_q == total_q - CNT_W'(1))) ||
                      (rsp_take && (rsp_q == total_q - CNT_W'(1)));

  always_comb begin
    kind_d  = kind_q;
    issue_d = issue_q;
    rsp_d   = rsp_q;
    total_d = total_q;
    base_d  = base_q;
    if (start) begin
      kind_d  = start_kind;
      issue_d = '0;
      rsp_d   = '0;
      total_d = {start_len, {($clog2(WORDS_PER_LN)){1'b0}}};
      base_d  = start_base;
    end else begin
      if (mem_req)  issue_d = issue_q + CNT_W'(1);
      if (rsp_take) rsp_d   = rsp_q + CNT_W'(1);
      if (done)     kind_d  = PASS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= PASS_IDLE;
      issue_q <= '0;
      rsp_q   <= '0;
      total_q <= '0;
      base_q  <= '0;
    end else begin
      kind_q  <= kind_d;
      issue_q <= issue_d;
      rsp_q   <= rsp_d;
      total_q <= total_d;
      base_q  <= base_d;
    end
  end

  assert_issue_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q != PASS_IDLE) |-> (issue_q <= total_q));
  assert_rsp_behind_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == PASS_RD) |-> (rsp_q <= issue_q));
  assert_done_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (kind_q == PASS_IDLE));
  assert_write_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_q == PASS_IDLE) && ($past(kind_q) == PASS_WR)) |-> (issue_q == total_q));
endmodule

// File: rtl/tpe_cmp.sv
module tpe_cmp
  import tpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [PORT_W-1:0] got,
  input  logic [PORT_W-1:0] want,
  output logic [LANES-1:0]  stat_first,
  output logic [LANES-1:0]  stat_second
);
  logic [LANES-1:0] miss_first, miss_second;
  logic [LANES-1:0] first_q, first_d, second_q, second_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign miss_first[i]  = got[8*i +: 8] != want[8*i +: 8];
    assign miss_second[i] = got[BEAT_W + 8*i +: 8] != want[BEAT_W + 8*i +: 8];
  end

  always_comb begin
    first_d  = first_q;
    second_d = second_q;
    if (clear) begin
      first_d  = '0;
      second_d = '0;
    end else if (take) begin
      first_d  = first_q | miss_first;
      second_d = second_q | miss_second;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      first_q  <= first_d;
      second_q <= second_d;
    end
  end

  assign stat_first  = first_q;
  assign stat_second = second_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((({second_q, first_q}) & $past({second_q, first_q})) == $past({second_q, first_q})));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !take) |=> $stable({second_q, first_q}));
endmodule

// File: rtl/train_pattern_engine.sv
module train_pattern_engine
  import tpe_pkg::*;
#(
  parameter int unsigned LINES_MAX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [REG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [PORT_W-1:0]  mem_wdata,
  input  logic               mem_rvalid,
  input  logic [PORT_W-1:0]  mem_rdata
);
  localparam int unsigned LEN_W  = $clog2(LINES_MAX + 1);
  localparam int unsigned IDX_W  = $clog2(LINES_MAX * DW_PER_LINE);
  localparam int unsigned WIDX_W = $clog2(LINES_MAX * WORDS_PER_LN);

  logic             wr_mode_q, wr_mode_d, rd_mode_q, rd_mode_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LO_W-1:0]  alo_q, alo_d;
  logic [HI_W-1:0]  ahi_q, ahi_d;
  logic [IDX_W-1:0] bptr_q, bptr_d;

  pass_e             kind;
  logic              busy, done, rsp_take;
  logic [WIDX_W-1:0] issue_word, rsp_word, buf_word;
  logic [PORT_W-1:0] buf_data;
  logic [LANES-1:0]  stat_first, stat_second;
  logic              ctrl_wr, bptr_wr, buf_we, len_ok, wr_start, rd_start, pass_start;
  logic [LEN_W-1:0]  new_len;

  assign busy     = kind != PASS_IDLE;
  assign ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL) && !busy;
  assign bptr_wr  = cfg_we && (cfg_addr == REG_BPTR) && !busy;
  assign buf_we   = cfg_we && (cfg_addr == REG_BDATA) && !busy;
  assign new_len  = cfg_wdata[LEN_LSB +: LEN_W];
  assign len_ok   = (new_len != '0) && (new_len <= LEN_W'(LINES_MAX));
  assign wr_start = ctrl_wr && len_ok && cfg_wdata[2] && !cfg_wdata[3] && cfg_wdata[0];
  assign rd_start = ctrl_wr && len_ok && cfg_wdata[3] && !cfg_wdata[2] && cfg_wdata[1];
  assign pass_start = wr_start || rd_start;

  always_comb begin
    wr_mode_d = wr_mode_q;
    rd_mode_d = rd_mode_q;
    len_d     = len_q;
    alo_d     = alo_q;
    ahi_d     = ahi_q;
    bptr_d    = bptr_q;
    if (ctrl_wr) begin
      wr_mode_d = cfg_wdata[0];
      rd_mode_d = cfg_wdata[1];
      len_d     = new_len;
    end
    if (cfg_we && (cfg_addr == REG_ALO)) alo_d = cfg_wdata;
    if (cfg_we && (cfg_addr == REG_AHI)) ahi_d = cfg_wdata[HI_W-1:0];
    if (pass_start)   bptr_d = '0;
    else if (bptr_wr) bptr_d = cfg_wdata[IDX_W-1:0];
    else if (buf_we)  bptr_d = bptr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_mode_q <= 1'b0;
      rd_mode_q <= 1'b0;
      len_q     <= '0;
      alo_q     <= '0;
      ahi_q     <= '0;
      bptr_q    <= '0;
    end else begin
      wr_mode_q <= wr_mode_d;
      rd_mode_q <= rd_mode_d;
      len_q     <= len_d;
      alo_q     <= alo_d;
      ahi_q     <= ahi_d;
      bptr_q    <= bptr_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL: begin
        cfg_rdata[0] = wr_mode_q;
        cfg_rdata[1] = rd_mode_q;
        cfg_rdata[2] = kind == PASS_WR;
        cfg_rdata[3] = kind == PASS_RD;
        cfg_rdata[LEN_LSB +: LEN_W] = len_q;
      end
      REG_BPTR:  cfg_rdata[IDX_W-1:0] = bptr_q;
      REG_ALO:   cfg_rdata = alo_q;
      REG_AHI:   cfg_rdata[HI_W-1:0] = ahi_q;
      REG_STAT:  cfg_rdata[2*LANES-1:0] = {stat_second, stat_first};
      default:   cfg_rdata = '0;
    endcase
  end

  assign buf_word  = (kind == PASS_RD) ? rsp_word : issue_word;
  assign mem_wdata = buf_data;

  tpe_patbuf #(.LINES_MAX(LINES_MAX)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (bptr_q),
    .wr_data (cfg_wdata),
    .rd_word (buf_word),
    .rd_data (buf_data)
  );

  tpe_seq #(.LINES_MAX(LINES_MAX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (pass_start),
    .start_kind (wr_start ? PASS_WR : PASS_RD),
    .start_len  (new_len),
    .start_base ({ahi_q, alo_q}),
    .rsp_valid  (mem_rvalid),
    .kind       (kind),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .issue_word (issue_word),
    .rsp_word   (rsp_word),
    .rsp_take   (rsp_take),
    .done       (done)
  );

  tpe_cmp u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (rd_start),
    .take        (rsp_take),
    .got         (mem_rdata),
    .want        (buf_data),
    .stat_first  (stat_first),
    .stat_second (stat_second)
  );

  assert_go_falls_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_ptr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bptr_q));
  assert_ptr_zero_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bptr_q == '0));
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kind == PASS_RD) |-> ({stat_second, stat_first} == '0));
  assert_no_req_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mem_req);
endmodule

// File: tb/test_train_pattern_engine.sv
module test_train_pattern_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         mem_req, mem_we;
  logic [35:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_rvalid;
  logic [127:0] mem_rdata;

  int checks = 0;
  int fails  = 0;

  always #5ns clk = ~clk;

  train_pattern_engine #(.LINES_MAX(4)) i_train_pattern_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: writes accepted each cycle, reads return two cycles later
  logic [127:0] mem  [64];
  logic [127:0] flip [64];
  logic         cnt_clr = 1'b0;
  int           wr_count, req_count;
  logic [35:0]  first_addr;
  logic         rd_p1;
  logic [5:0]   rd_a1;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_p1 <= 1'b0; mem_rvalid <= 1'b0; wr_count <= 0; req_count <= 0;
    end else begin
      if (cnt_clr) begin
        wr_count <= 0; req_count <= 0;
      end else if (mem_req) begin
        req_count <= req_count + 1;
        if (req_count == 0) first_addr <= mem_addr;
        if (mem_we) begin
          wr_count <= wr_count + 1;
          mem[mem_addr[5:0]] <= mem_wdata;
        end
      end
      rd_p1      <= mem_req && !mem_we;
      rd_a1      <= mem_addr[5:0];
      mem_rvalid <= rd_p1;
      mem_rdata  <= mem[rd_a1] ^ flip[rd_a1];
    end
  end

  function automatic logic [31:0] pat(int k);
    return {8'(k * 7 + 3), 8'(k + 64), 8'(k * 3 + 128), 8'(~k)};
  endfunction

  function automatic logic [127:0] pword(int w);
    return {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
  endfunction

  function automatic logic [31:0] ctrl(int len, bit wm, bit rm, bit wg, bit rg);
    return (32'(len) << 8) | {28'd0, rg, wg, rm, wm};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1ns;
    d = cfg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      rd(3'd0, v);
      if (v[3:2] == 2'b00) begin ok = 1'b1; break; end
    end
  endtask

  task automatic clr_counts();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic read_pass(int len, output logic [31:0] st);
    bit ok;
    wr(3'd0, ctrl(len, 0, 1, 0, 1));
    wait_idle(ok);
    if (!ok) chk(0, "R3 read pass hung", 0, 1);
    rd(3'd5, st);
  endtask

  initial begin
    logic [31:0] v, st, exp32;
    bit ok;
    for (int i = 0; i < 64; i++) flip[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, $sformatf("R12 reg %0d after reset", a), v, 0);
    end
    chk(mem_req == 1'b0, "R12 no request after reset", mem_req, 0);

    // R1 pointer auto-increment and wrap
    wr(3'd1, 32'd60);
    for (int i = 0; i < 5; i++) wr(3'd2, 32'hFFFF_0000 + i);
    rd(3'd1, v);
    chk(v == 1, "R1 pointer wraps at 64", v, 1);
    wr(3'd1, 32'd0);
    for (int i = 0; i < 64; i++) wr(3'd2, pat(i));
    rd(3'd1, v);
    chk(v == 0, "R1 pointer after 64 writes", v, 0);

    wr(3'd3, 32'd3);
    wr(3'd4, 32'd2);

    // R2 / R3 / R6 write passes for every length, then clean read (R7)
    for (int len = 1; len <= 4; len++) begin
      wr(3'd1, 32'd7);
      clr_counts();
      wr(3'd0, ctrl(len, 1, 0, 1, 0));
      rd(3'd0, v);
      chk(v[3:2] == 2'b01, $sformatf("R3 write go set len %0d", len), v[3:2], 1);
      rd(3'd1, v);
      chk(v == 0, "R6 pointer cleared at start", v, 0);
      wait_idle(ok);
      chk(ok, "R3 write go cleared", ok, 1);
      chk(wr_count == 4*len, $sformatf("R2 write count len %0d", len), wr_count, 4*len);
      chk(first_addr == {2'b10, 32'd3, 2'b00}, "R2 first address", first_addr, {2'b10, 32'd3, 2'b00});
      for (int w = 0; w < 4*len; w++)
        chk(mem[12+w] == pword(w), $sformatf("R2 R6 word %0d len %0d", w, len), mem[12+w], pword(w));
      clr_counts();
      read_pass(len, st);
      chk(req_count == 4*len, "R7 read request count", req_count, 4*len);
      chk(st == 0, $sformatf("R7 clean read len %0d", len), st, 0);
    end

    // R8 / R10 exhaustive lane and position sweep; each run expects an exact map (R9 clear)
    for (int j = 0; j < 16; j++) begin
      for (int b = 0; b < 16; b++) begin
        flip[12+j] = 128'hFF << (8*b);
        read_pass(4, st);
        exp32 = 32'd1 << b;
        chk(st == exp32, (j == 15) ? "R10 last word lane" : "R8 lane map", st, exp32);
        flip[12+j] = '0;
      end
    end

    // R9 sticky accumulation, then cleared on the next pass
    flip[14] = 128'hFF << 8;
    flip[17] = 128'hFF << 8;
    flip[26] = 128'hFF << (8*14);
    read_pass(4, st);
    chk(st == 32'h4002, "R9 sticky bits", st, 32'h4002);
    flip[14] = '0; flip[17] = '0; flip[26] = '0;
    read_pass(4, st);
    chk(st == 0, "R9 cleared at new pass", st, 0);

    // R4 refused starts
    clr_counts();
    wr(3'd0, ctrl(2, 0, 0, 1, 0));
    rd(3'd0, v);
    chk(v[3:2] == 0, "R4 write go without mode", v[3:2], 0);
    wr(3'd0, ctrl(2, 1, 1, 1, 1));
    rd(3'd0, v);
    chk(v[3:2] == 0, "R4 both go bits", v[3:2], 0);
    wr(3'd0, ctrl(2, 1, 0, 0, 1));
    rd(3'd0, v);
    chk(v[3:2] == 0, "R4 read go with write mode", v[3:2], 0);
    // R5 length out of range
    wr(3'd0, ctrl(0, 1, 0, 1, 0));
    rd(3'd0, v);
    chk(v[3:2] == 0, "R5 length zero", v[3:2], 0);
    wr(3'd0, ctrl(5, 1, 0, 1, 0));
    rd(3'd0, v);
    chk(v[3:2] == 0, "R5 length above max", v[3:2], 0);
    repeat (5) @(negedge clk);
    chk(req_count == 0, "R4 R5 no requests", req_count, 0);

    // R11 writes during a pass are dropped
    wr(3'd0, ctrl(4, 0, 1, 0, 1));
    wr(3'd1, 32'd9);
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd0, ctrl(1, 1, 0, 0, 0));
    wait_idle(ok);
    rd(3'd1, v);
    chk(v == 0, "R11 pointer untouched", v, 0);
    rd(3'd0, v);
    chk(v == ctrl(4, 0, 1, 0, 0), "R11 control untouched", v, ctrl(4, 0, 1, 0, 0));
    wr(3'd0, ctrl(4, 1, 0, 1, 0));
    wait_idle(ok);
    ok = 1'b1;
    for (int w = 0; w < 16; w++) if (mem[12+w] != pword(w)) ok = 1'b0;
    chk(ok, "R11 pattern intact", ok, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule